// File: doc/BRIEF.md
# Reference Divider, Phase/Frequency Detector and Lock Monitor

This block is the digital core of a tuner synthesizer loop. It runs on the 4 MHz crystal clock and divides it by one of three ratios to make the comparison reference. A three-state phase/frequency detector compares that reference with the output of the programmable VCO divider. The detector asks the external charge pump to source current, to sink current, or to stay in high impedance. A lock monitor watches how wide the correction pulses are and raises a flag once the loop has settled.

Control bits come from the serial control bytes held elsewhere. Two bits pick the reference ratio. A three-bit test field either leaves the detector alone or forces the pump into a fixed state. The same field also sets a pin-select code, so that the reference or the divided VCO clock can be brought out on a shared test pin in place of the ADC input. Two further bits are passed through: the pump current level and the tuning-amplifier enable. The divided VCO signal is assumed to be synchronous to the crystal clock already.

Top module: `refPhaseLock`

## Requirements
- R1: The reference period is 512 crystal cycles when rateSelA=1 and rateSelB=1, 1024 cycles when rateSelA=0 and rateSelB=1, and 640 cycles whenever rateSelB=0. refOut is high for the first half of each period.
- R2: A change of the ratio select restarts the reference counter from zero at the next clock edge. The first full reference period that follows is exactly the new length.
- R3: When the rising edge of divIn comes L cycles before the reference edge, pumpUp (source) is high for exactly L consecutive cycles.
- R4: When the rising edge of divIn comes L cycles after the reference edge, pumpDown (sink) is high for exactly L consecutive cycles.
- R5: When both edges fall in the same cycle, neither pumpUp nor pumpDown is set. In every cycle exactly one of pumpUp, pumpDown and pumpHiZ is high.
- R6: With testMode[2]=0, the detector drives the pump outputs and testPinSel is 00 (ADC input). testClk is 0.
- R7: testMode=110 forces sink (pumpDown=1), and testMode=111 forces source (pumpUp=1). In both cases testPinSel is 00.
- R8: testMode=100 forces high impedance and sets testPinSel=01, with testClk following refOut. testMode=101 forces high impedance and sets testPinSel=10, with testClk following divIn.
- R9: pumpCurHigh follows pumpCurSel. A value of 1 selects the high pump current.
- R10: ampEnable is the inverse of ampOffSel.
- R11: lockFlag goes to 1 on a reference edge that ends four consecutive reference periods in which no pump pulse lasted 2 or more cycles.
- R12: A pump pulse that reaches 2 cycles clears lockFlag at the next edge. It also spoils the count for the reference period in progress.
- R13: During and right after reset, lockFlag=0, pumpHiZ=1 and the reference ratio is 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSelA | input | 1 | Ratio select bit A |
| rateSelB | input | 1 | Ratio select bit B |
| testMode | input | 3 | Test field, bit 2 enables the forced modes |
| pumpCurSel | input | 1 | Pump current select (1 = high) |
| ampOffSel | input | 1 | Tuning amplifier off request |
| divIn | input | 1 | Divided VCO signal |
| pumpUp | output | 1 | Charge pump source request |
| pumpDown | output | 1 | Charge pump sink request |
| pumpHiZ | output | 1 | Charge pump high impedance |
| pumpCurHigh | output | 1 | High current level selected |
| ampEnable | output | 1 | Tuning amplifier on |
| lockFlag | output | 1 | Loop lock indication |
| testPinSel | output | 2 | Test pin source: 00 ADC, 01 reference, 10 divided VCO |
| testClk | output | 1 | Clock routed to the test pin |
| refOut | output | 1 | Reference clock |

## Verification
The hardest situation to reach from the ports is one where the divided VCO edge sits a chosen number of cycles before or after the reference edge. The lock count, the pulse widths and the coincident case all depend on that offset. The bench keeps its own count of the reference phase and generates divIn from that count, so each segment places the VCO edge at an exact lead or lag: 0, 1, 2, 5 or 7 cycles. The restart check does the same. It waits until the reference count is deep inside a period and only then changes the ratio, so that a restart and a carried-on count give clearly different periods.

// File: rtl/refPhasePkg.sv
package refPhasePkg;

  typedef enum logic [1:0] {
    RATE_512  = 2'b00,
    RATE_640  = 2'b01,
    RATE_1024 = 2'b10
  } rate_e;

  typedef enum logic [1:0] {
    FORCE_NONE   = 2'b00,
    FORCE_SINK   = 2'b01,
    FORCE_SOURCE = 2'b10,
    FORCE_HIZ    = 2'b11
  } force_e;

  typedef enum logic [1:0] {
    PIN_ADC = 2'b00,
    PIN_REF = 2'b01,
    PIN_DIV = 2'b10
  } pinSel_e;

  typedef struct packed {
    rate_e   rate;
    force_e  forceMode;
    pinSel_e pinSel;
    logic    curHigh;
    logic    ampOn;
  } ctrlStrobe_t;

endpackage

// File: rtl/refPhaseCtrl.sv
module refPhaseCtrl
  import refPhasePkg::*;
(
  input  logic        rateSelA,
  input  logic        rateSelB,
  input  logic [2:0]  testMode,
  input  logic        pumpCurSel,
  input  logic        ampOffSel,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe = '0;

    // Ratio: B low always gives 640, otherwise A picks 512 or 1024
    if (!rateSelB)     strobe.rate = RATE_640;
    else if (rateSelA) strobe.rate = RATE_512;
    else               strobe.rate = RATE_1024;

    // Test field decode
    casez (testMode)
      3'b0??: begin strobe.forceMode = FORCE_NONE;   strobe.pinSel = PIN_ADC; end
      3'b110: begin strobe.forceMode = FORCE_SINK;   strobe.pinSel = PIN_ADC; end
      3'b111: begin strobe.forceMode = FORCE_SOURCE; strobe.pinSel = PIN_ADC; end
      3'b100: begin strobe.forceMode = FORCE_HIZ;    strobe.pinSel = PIN_REF; end
      default: begin strobe.forceMode = FORCE_HIZ;   strobe.pinSel = PIN_DIV; end
    endcase

    strobe.curHigh = pumpCurSel;
    strobe.ampOn   = ~ampOffSel;
  end

endmodule

// File: rtl/refPhaseDatapath.sv
module refPhaseDatapath
  import refPhasePkg::*;
#(
  parameter int RATE_A_DIV = 512,
  parameter int RATE_B_DIV = 640,
  parameter int RATE_C_DIV = 1024,
  parameter int LOCK_WIDTH = 2,
  parameter int LOCK_COUNT = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        divIn,
  output logic        pumpUp,
  output logic        pumpDown,
  output logic        pumpHiZ,
  output logic        lockFlag,
  output logic [1:0]  testPinSel,
  output logic        testClk,
  output logic        refOut
);

  localparam int MAX_AB  = (RATE_A_DIV > RATE_B_DIV) ? RATE_A_DIV : RATE_B_DIV;
  localparam int MAX_DIV = (MAX_AB > RATE_C_DIV) ? MAX_AB : RATE_C_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam int RUN_W   = $clog2(LOCK_WIDTH + 1);
  localparam int GOOD_W  = $clog2(LOCK_COUNT + 1);

  localparam logic [CNT_W-1:0] TERM_A = CNT_W'(RATE_A_DIV - 1);
  localparam logic [CNT_W-1:0] TERM_B = CNT_W'(RATE_B_DIV - 1);
  localparam logic [CNT_W-1:0] TERM_C = CNT_W'(RATE_C_DIV - 1);
  localparam logic [CNT_W-1:0] HALF_A = CNT_W'(RATE_A_DIV / 2);
  localparam logic [CNT_W-1:0] HALF_B = CNT_W'(RATE_B_DIV / 2);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(RATE_C_DIV / 2);
  localparam logic [RUN_W-1:0]  RUN_MAX   = RUN_W'(LOCK_WIDTH);
  localparam logic [RUN_W-1:0]  RUN_WIDE  = RUN_W'(LOCK_WIDTH - 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(LOCK_COUNT);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);

  // ---------------- Reference divider ----------------
  logic [CNT_W-1:0] refCnt;
  logic [CNT_W-1:0] termCnt;
  logic [CNT_W-1:0] halfCnt;
  rate_e            prevRate;
  logic             rateChg;
  logic             refTick;

  always_comb begin
    unique case (strobe.rate)
      RATE_512: begin termCnt = TERM_A; halfCnt = HALF_A; end
      RATE_640: begin termCnt = TERM_B; halfCnt = HALF_B; end
      default:  begin termCnt = TERM_C; halfCnt = HALF_C; end
    endcase
  end

  assign rateChg = (strobe.rate != prevRate);
  assign refTick = !rateChg && (refCnt == termCnt);
  assign refOut  = (refCnt < halfCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt   <= '0;
      prevRate <= RATE_1024;
    end else begin
      prevRate <= strobe.rate;
      if (rateChg || refCnt == termCnt) refCnt <= '0;
      else                              refCnt <= refCnt + 1'b1;
    end
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    rateChg |=> (refCnt == '0));

  // ---------------- Phase/frequency detector ----------------
  logic divPrev;
  logic divEdge;
  logic upQ, dnQ;
  logic upSet, dnSet;

  assign divEdge = divIn && !divPrev;
  assign upSet   = upQ || divEdge;
  assign dnSet   = dnQ || refTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divPrev <= 1'b0;
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
    end else begin
      divPrev <= divIn;
      upQ     <= upSet && !dnSet;
      dnQ     <= dnSet && !upSet;
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(upQ && dnQ));

  // ---------------- Lock monitor ----------------
  logic [RUN_W-1:0]  runCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic              periodBad;
  logic              lockQ;
  logic              pulseActive;
  logic              widePulse;

  assign pulseActive = upQ || dnQ;
  assign widePulse   = pulseActive && (runCnt >= RUN_WIDE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      goodCnt   <= '0;
      periodBad <= 1'b0;
      lockQ     <= 1'b0;
    end else begin
      if (!pulseActive)          runCnt <= '0;
      else if (runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;

      if (widePulse) begin
        lockQ     <= 1'b0;
        goodCnt   <= '0;
        periodBad <= 1'b1;
      end else if (refTick) begin
        if (periodBad) begin
          goodCnt   <= '0;
          periodBad <= 1'b0;
        end else begin
          if (goodCnt != GOOD_MAX) goodCnt <= goodCnt + 1'b1;
          if (goodCnt >= GOOD_LAST) lockQ <= 1'b1;
        end
      end
    end
  end

  assign lockFlag = lockQ;

  assert_lock_on_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(refTick));

  generate
    if (LOCK_WIDTH == 2) begin : g_wideCheck
      assert_wide_drop_R12: assert property (@(posedge clk) disable iff (!rstN)
        (pulseActive && $past(pulseActive)) |=> !lockQ);
    end
  endgenerate

  // ---------------- Output forcing and test pin ----------------
  always_comb begin
    unique case (strobe.forceMode)
      FORCE_SINK:   begin pumpUp = 1'b0; pumpDown = 1'b1; pumpHiZ = 1'b0; end
      FORCE_SOURCE: begin pumpUp = 1'b1; pumpDown = 1'b0; pumpHiZ = 1'b0; end
      FORCE_HIZ:    begin pumpUp = 1'b0; pumpDown = 1'b0; pumpHiZ = 1'b1; end
      default:      begin pumpUp = upQ;  pumpDown = dnQ;  pumpHiZ = !(upQ || dnQ); end
    endcase

    testPinSel = strobe.pinSel;
    unique case (strobe.pinSel)
      PIN_REF: testClk = refOut;
      PIN_DIV: testClk = divIn;
      default: testClk = 1'b0;
    endcase
  end

  assert_one_state_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({pumpUp, pumpDown, pumpHiZ}) == 1);

  assert_force_sink_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.forceMode == FORCE_SINK) |-> (pumpDown && !pumpUp));

  assert_pin_ref_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pinSel == PIN_REF) |-> (pumpHiZ && testClk == refOut));

endmodule

// File: rtl/refPhaseLock.sv
module refPhaseLock
  import refPhasePkg::*;
#(
  parameter int RATE_A_DIV = 512,
  parameter int RATE_B_DIV = 640,
  parameter int RATE_C_DIV = 1024,
  parameter int LOCK_WIDTH = 2,
  parameter int LOCK_COUNT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateSelA,
  input  logic       rateSelB,
  input  logic [2:0] testMode,
  input  logic       pumpCurSel,
  input  logic       ampOffSel,
  input  logic       divIn,
  output logic       pumpUp,
  output logic       pumpDown,
  output logic       pumpHiZ,
  output logic       pumpCurHigh,
  output logic       ampEnable,
  output logic       lockFlag,
  output logic [1:0] testPinSel,
  output logic       testClk,
  output logic       refOut
);

  ctrlStrobe_t strobe;

  refPhaseCtrl i_ctrl (
    .rateSelA  (rateSelA),
    .rateSelB  (rateSelB),
    .testMode  (testMode),
    .pumpCurSel(pumpCurSel),
    .ampOffSel (ampOffSel),
    .strobe    (strobe)
  );

  refPhaseDatapath #(
    .RATE_A_DIV(RATE_A_DIV),
    .RATE_B_DIV(RATE_B_DIV),
    .RATE_C_DIV(RATE_C_DIV),
    .LOCK_WIDTH(LOCK_WIDTH),
    .LOCK_COUNT(LOCK_COUNT)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .divIn     (divIn),
    .pumpUp    (pumpUp),
    .pumpDown  (pumpDown),
    .pumpHiZ   (pumpHiZ),
    .lockFlag  (lockFlag),
    .testPinSel(testPinSel),
    .testClk   (testClk),
    .refOut    (refOut)
  );

  assign pumpCurHigh = strobe.curHigh;
  assign ampEnable   = strobe.ampOn;

endmodule

// File: tb/test_refPhaseLock.sv
module test_refPhaseLock;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rateSelA = 1'b0;
  logic       rateSelB = 1'b1;
  logic [2:0] testMode = 3'b000;
  logic       pumpCurSel = 1'b1;
  logic       ampOffSel = 1'b1;
  logic       divIn = 1'b0;
  logic       pumpUp, pumpDown, pumpHiZ, pumpCurHigh, ampEnable, lockFlag;
  logic [1:0] testPinSel;
  logic       testClk, refOut;

  refPhaseLock i_refPhaseLock (
    .clk(clk), .rstN(rstN), .rateSelA(rateSelA), .rateSelB(rateSelB),
    .testMode(testMode), .pumpCurSel(pumpCurSel), .ampOffSel(ampOffSel),
    .divIn(divIn), .pumpUp(pumpUp), .pumpDown(pumpDown), .pumpHiZ(pumpHiZ),
    .pumpCurHigh(pumpCurHigh), .ampEnable(ampEnable), .lockFlag(lockFlag),
    .testPinSel(testPinSel), .testClk(testClk), .refOut(refOut)
  );

  always #10 clk = ~clk;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 0;

  // Behavioural reference state
  int  mCnt = 0, mPrevN = 1024, mRun = 0, mGood = 0;
  bit  mDivPrev = 0, mUp = 0, mDn = 0, mBad = 0, mLock = 0;

  // divIn generator: 0 off, 1 lead, 2 lag
  int  divMode = 0;
  int  divOffset = 0;

  function automatic int curN();
    if (!rateSelB) return 640;
    if (rateSelA)  return 512;
    return 1024;
  endfunction

  function automatic bit genDiv();
    int n, tgt;
    n = curN();
    if (divMode == 0) return 1'b0;
    if (divMode == 1) tgt = n - 1 - divOffset;
    else              tgt = divOffset - 1;
    return (((mCnt - tgt) % n + n) % n) < (n / 2);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int n;
    bit eu, ed, eh, eClk, eRef;
    int es;
    n    = curN();
    eRef = (mCnt < n / 2);
    eu = mUp; ed = mDn; eh = !(mUp || mDn); es = 0; eClk = 1'b0;
    if (testMode[2]) begin
      case (testMode[1:0])
        2'b10: begin eu = 0; ed = 1; eh = 0; end
        2'b11: begin eu = 1; ed = 0; eh = 0; end
        2'b00: begin eu = 0; ed = 0; eh = 1; es = 1; eClk = eRef; end
        default: begin eu = 0; ed = 0; eh = 1; es = 2; eClk = divIn; end
      endcase
    end
    check("R3", pumpUp, eu, "pumpUp");
    check("R4", pumpDown, ed, "pumpDown");
    check("R5", pumpHiZ, eh, "pumpHiZ");
    check("R11", lockFlag, mLock, "lockFlag");
    check("R8", testPinSel, es, "testPinSel");
    check("R8", testClk, eClk, "testClk");
    check("R1", refOut, eRef, "refOut");
    check("R9", pumpCurHigh, pumpCurSel, "pumpCurHigh");
    check("R10", ampEnable, !ampOffSel, "ampEnable");
  endtask

  task automatic modelStep();
    int n;
    bit chg, tk, edg, act, wide, nu, nd;
    if (!rstN) begin
      mCnt = 0; mPrevN = 1024; mRun = 0; mGood = 0;
      mDivPrev = 0; mUp = 0; mDn = 0; mBad = 0; mLock = 0;
      return;
    end
    n    = curN();
    chg  = (n != mPrevN);
    tk   = !chg && (mCnt == n - 1);
    edg  = divIn && !mDivPrev;
    act  = mUp || mDn;
    wide = act && (mRun >= 1);
    nu = mUp || edg;
    nd = mDn || tk;
    if (nu && nd) begin nu = 0; nd = 0; end
    if (wide) begin
      mLock = 0; mGood = 0; mBad = 1;
    end else if (tk) begin
      if (mBad) begin mGood = 0; mBad = 0; end
      else begin
        if (mGood >= 3) mLock = 1;
        if (mGood < 4) mGood++;
      end
    end
    mRun     = act ? ((mRun < 2) ? mRun + 1 : 2) : 0;
    mCnt     = (chg || mCnt == n - 1) ? 0 : mCnt + 1;
    mPrevN   = n;
    mDivPrev = divIn;
    mUp      = nu;
    mDn      = nd;
  endtask

  // One cycle: drive, settle, compare, advance model, wait next negedge
  task automatic tick();
    divIn = genDiv();
    #1;
    compareAll();
    modelStep();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic measurePeriod(output int p);
    bit prev;
    p = 0;
    for (int i = 0; i < 3000; i++) begin
      prev = refOut; tick();
      if (!prev && refOut) break;
    end
    for (int i = 0; i < 3000; i++) begin
      prev = refOut; tick(); p++;
      if (!prev && refOut) break;
    end
  endtask

  task automatic maxRuns(int n, output int upMax, output int dnMax, output int busy);
    int ur, dr;
    ur = 0; dr = 0; upMax = 0; dnMax = 0; busy = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      ur = pumpUp ? ur + 1 : 0;
      dr = pumpDown ? dr + 1 : 0;
      if (ur > upMax) upMax = ur;
      if (dr > dnMax) dnMax = dr;
      if (pumpUp || pumpDown) busy++;
    end
  endtask

  initial begin
    int p, um, dm, busy, n;
    bit prev, sawLow;
    @(negedge clk);
    run(5);
    // R13: reset state
    check("R13", lockFlag, 0, "lockFlag in reset");
    check("R13", pumpHiZ, 1, "pumpHiZ in reset");
    rstN = 1'b1;
    tick();
    check("R13", lockFlag, 0, "lockFlag after reset");
    measurePeriod(p);
    check("R13", p, 1024, "reset ratio period");

    // R1: ratio decode
    rateSelA = 1; rateSelB = 1; measurePeriod(p); check("R1", p, 512, "period 11");
    rateSelA = 0; rateSelB = 1; measurePeriod(p); check("R1", p, 1024, "period 01");
    rateSelA = 0; rateSelB = 0; measurePeriod(p); check("R1", p, 640, "period 00");
    rateSelA = 1; rateSelB = 0; measurePeriod(p); check("R1", p, 640, "period 10");

    // R2: restart on ratio change, taken mid-period
    rateSelA = 1; rateSelB = 1;
    for (int i = 0; i < 2000 && mCnt != 300; i++) tick();
    rateSelA = 0; tick();
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      prev = refOut; tick(); n++;
      if (!prev && refOut) break;
    end
    check("R2", n, 1024, "first period after change");

    // R11: one-cycle lead pulses give lock
    rateSelA = 1; rateSelB = 1;
    divMode = 1; divOffset = 1;
    run(8 * 512);
    check("R11", lockFlag, 1, "lock after clean periods");

    // R12: two-cycle pulse drops lock within a period
    divOffset = 2;
    sawLow = 0;
    for (int i = 0; i < 600; i++) begin tick(); if (!lockFlag) sawLow = 1; end
    check("R12", sawLow, 1, "lock dropped on wide pulse");

    // R3: lead of 5
    divOffset = 5; run(1024);
    maxRuns(3 * 512, um, dm, busy);
    check("R3", um, 5, "source width");
    check("R3", dm, 0, "no sink on lead");
    check("R12", lockFlag, 0, "lock stays low");

    // R4: lag of 7
    divMode = 2; divOffset = 7; run(1024);
    maxRuns(3 * 512, um, dm, busy);
    check("R4", dm, 7, "sink width");
    check("R4", um, 0, "no source on lag");

    // R5: coincident edges
    divMode = 1; divOffset = 0; run(1024);
    maxRuns(3 * 512, um, dm, busy);
    check("R5", busy, 0, "no pump activity when aligned");

    // Back to lock for test modes
    divOffset = 1; run(8 * 512);
    check("R11", lockFlag, 1, "relock");

    // R6: normal modes
    testMode = 3'b010;
    maxRuns(2 * 512, um, dm, busy);
    check("R6", busy, 2, "detector drives pump in 010");
    check("R6", testPinSel, 0, "pin ADC in 010");
    testMode = 3'b001; tick();
    check("R6", testPinSel, 0, "pin ADC in 001");
    check("R6", testClk, 0, "testClk idle in 001");

    // R7: forced sink / source
    testMode = 3'b110; tick();
    check("R7", pumpDown, 1, "forced sink");
    check("R7", pumpUp, 0, "no source when sinking");
    testMode = 3'b111; tick();
    check("R7", pumpUp, 1, "forced source");
    check("R7", testPinSel, 0, "pin ADC in 111");

    // R8: routed clocks
    testMode = 3'b100; run(300);
    check("R8", pumpHiZ, 1, "hi-Z in 100");
    check("R8", testPinSel, 1, "pin ref in 100");
    check("R8", testClk, refOut, "testClk is ref");
    testMode = 3'b101; run(300);
    check("R8", testPinSel, 2, "pin div in 101");
    check("R8", testClk, divIn, "testClk is div");
    testMode = 3'b000;

    // R9 / R10: pass-through bits
    pumpCurSel = 0; tick(); check("R9", pumpCurHigh, 0, "low current");
    pumpCurSel = 1; tick(); check("R9", pumpCurHigh, 1, "high current");
    ampOffSel = 0; tick(); check("R10", ampEnable, 1, "amp on");
    ampOffSel = 1; tick(); check("R10", ampEnable, 0, "amp off");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule